// File: doc/BRIEF.md
# Half-Bridge Gate Input Conditioner with Over-Current Latch

This block sits between four logic-level control inputs from a microcontroller and the enables of four gate drivers: a power-factor stage driver, the low and high switches of a half-bridge, and a filament heater driver. Each input is passed to its driver enable through one register. The path is qualified by a global driver-enable from the power-mode sequencer. When that enable is low, as it is during start-up, every driver enable is held low.

Two protections act on the half-bridge pair only. The first is a cross-conduction interlock. Whenever the low-side and high-side inputs are both high, both half-bridge enables are held low, and they are released as soon as the conflict ends. The second is an over-current latch. A synchronized sense-comparator flag arms the latch only while the chip is in operating mode. Once set, the latch blanks both half-bridge enables and raises a status output. The latch is released in two ways: both half-bridge inputs are low in the same cycle while the sense flag is low, or the sequencer reports an undervoltage exit. The power-factor and heater paths ignore the latch.

Top module: `gim_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four gate enables and the fault status output are 0.
- R2: When the global driver enable is 0 in a cycle, all four gate enables are 0 after the next clock edge.
- R3: With the driver enable 1, no latched fault and no half-bridge conflict, each gate enable equals its control input one clock edge later.
- R4: When the low-side and high-side inputs are both 1 in a cycle, both half-bridge enables are 0 after the next edge. The next edge with the conflict gone lets them follow their inputs again.
- R5: A sense flag of 1 sampled while operating mode is 1 sets the fault latch. From that same edge, the status output is 1 and both half-bridge enables are 0.
- R6: A sense flag of 1 sampled while operating mode is 0 does not set the latch. The status output stays 0 and the half-bridge enables keep following their inputs.
- R7: A set latch clears only at an edge where the low-side input, the high-side input and the sense flag are all 0. If any one of the three is 1, the latch holds.
- R8: An undervoltage-exit pulse clears the latch at the next edge. It takes priority over a sense trip in the same cycle.
- R9: The power-factor and heater enables are not affected by the fault latch. With the driver enable 1, each follows its own input one edge later.
- R10: The status output is 0 whenever no fault is latched, including in operating mode with the sense flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Global driver enable from the mode sequencer |
| op_mode | input | 1 | High while in operating mode; arms over-current detection |
| uv_clr | input | 1 | Undervoltage exit from operating mode; clears the fault latch |
| pf_in | input | 1 | Power-factor stage control input |
| ls_in | input | 1 | Half-bridge low-side control input |
| hs_in | input | 1 | Half-bridge high-side control input |
| ht_in | input | 1 | Heater control input |
| oc_trip | input | 1 | Synchronized over-current comparator flag |
| pf_gate | output | 1 | Power-factor driver enable |
| ls_gate | output | 1 | Low-side driver enable |
| hs_gate | output | 1 | High-side driver enable |
| ht_gate | output | 1 | Heater driver enable |
| oc_flag | output | 1 | Latched over-current status |

## Verification
The bench runs every combination of the eight inputs several times, in a scrambled order, against fault states both set and clear. This targets the clear rule of the latch. A design that clears on only one half-bridge input low, or that ignores the sense flag when clearing, releases the blanking early and lets the half-bridge switch into a fault. A trip that arms outside operating mode shows up as a status flag raised during save mode. Directed sequences check the same-edge blanking on a trip. A design that blanked one cycle late would let one more switching pulse through. Further sequences check that the undervoltage clear wins over a simultaneous trip, and that the power-factor and heater paths pass through a fault untouched.

// File: rtl/gim_pkg.sv
package gim_pkg;

   localparam int unsigned GIM_N_GATES = 4;

   // bit order of the registered gate vector
   typedef enum logic [1:0] {
      GIDX_PF = 2'd0,
      GIDX_LS = 2'd1,
      GIDX_HS = 2'd2,
      GIDX_HT = 2'd3
   } gate_idx_e;

   typedef struct packed {
      logic ht;
      logic hs;
      logic ls;
      logic pf;
   } gate_vec_t;

   // interlock variants
   localparam int unsigned GIM_ILK_OFF  = 0;
   localparam int unsigned GIM_ILK_BOTH = 1;

   // fault clear variants
   localparam int unsigned GIM_CLR_SENSE_ONLY  = 0;
   localparam int unsigned GIM_CLR_IDLE_SENSE  = 1;

endpackage

// File: rtl/gim_hb_interlock.sv
module gim_hb_interlock #(
   parameter int unsigned MODE = gim_pkg::GIM_ILK_BOTH
) (
   input  logic ls_req,
   input  logic hs_req,
   output logic ls_ok,
   output logic hs_ok
);

   logic conflict;

   generate
      if (MODE == gim_pkg::GIM_ILK_BOTH) begin : g_ilk
         assign conflict = ls_req & hs_req;
      end else if (MODE == gim_pkg::GIM_ILK_OFF) begin : g_noilk
         assign conflict = 1'b0;
      end else begin : g_bad
         $error("gim_hb_interlock: MODE out of range");
         assign conflict = 1'b0;
      end
   endgenerate

   assign ls_ok = ls_req & ~conflict;
   assign hs_ok = hs_req & ~conflict;

endmodule

// File: rtl/gim_oc_latch.sv
module gim_oc_latch #(
   parameter int unsigned CLR_MODE = gim_pkg::GIM_CLR_IDLE_SENSE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic trip,
   input  logic uv_clr,
   input  logic ls_req,
   input  logic hs_req,
   output logic fault_nxt,
   output logic fault_q
);

   logic release_ok;

   generate
      if (CLR_MODE == gim_pkg::GIM_CLR_IDLE_SENSE) begin : g_idle
         assign release_ok = ~ls_req & ~hs_req & ~trip;
      end else if (CLR_MODE == gim_pkg::GIM_CLR_SENSE_ONLY) begin : g_sense
         assign release_ok = ~trip;
      end else begin : g_bad
         $error("gim_oc_latch: CLR_MODE out of range");
         assign release_ok = 1'b0;
      end
   endgenerate

   // undervoltage exit wins, then a new trip, then the release rule
   always_comb begin
      if (uv_clr)
         fault_nxt = 1'b0;
      else if (arm & trip)
         fault_nxt = 1'b1;
      else if (release_ok)
         fault_nxt = 1'b0;
      else
         fault_nxt = fault_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fault_q <= 1'b0;
      else
         fault_q <= fault_nxt;
   end

endmodule

// File: rtl/gim_gate_reg.sv
module gim_gate_reg #(
   parameter int unsigned W = gim_pkg::GIM_N_GATES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad
         $error("gim_gate_reg: W must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= 1'b0;
            else
               q[i] <= en & d[i];
         end
      end
   endgenerate

endmodule

// File: rtl/gim_top.sv
module gim_top #(
   parameter int unsigned ILK_MODE = gim_pkg::GIM_ILK_BOTH,
   parameter int unsigned CLR_MODE = gim_pkg::GIM_CLR_IDLE_SENSE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drv_en,
   input  logic op_mode,
   input  logic uv_clr,
   input  logic pf_in,
   input  logic ls_in,
   input  logic hs_in,
   input  logic ht_in,
   input  logic oc_trip,
   output logic pf_gate,
   output logic ls_gate,
   output logic hs_gate,
   output logic ht_gate,
   output logic oc_flag
);
   import gim_pkg::*;

   localparam int unsigned NG = GIM_N_GATES;

   logic      ls_ok, hs_ok;
   logic      fault_nxt, fault_q;
   gate_vec_t gate_d, gate_q;

   gim_hb_interlock #(.MODE(ILK_MODE)) u_ilk (
      .ls_req (ls_in),
      .hs_req (hs_in),
      .ls_ok  (ls_ok),
      .hs_ok  (hs_ok)
   );

   gim_oc_latch #(.CLR_MODE(CLR_MODE)) u_ocl (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (op_mode),
      .trip      (oc_trip),
      .uv_clr    (uv_clr),
      .ls_req    (ls_in),
      .hs_req    (hs_in),
      .fault_nxt (fault_nxt),
      .fault_q   (fault_q)
   );

   // half-bridge uses next fault state so blanking lands on the trip edge
   always_comb begin
      gate_d.pf = pf_in;
      gate_d.ht = ht_in;
      gate_d.ls = ls_ok & ~fault_nxt;
      gate_d.hs = hs_ok & ~fault_nxt;
   end

   gim_gate_reg #(.W(NG)) u_greg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (drv_en),
      .d     (gate_d),
      .q     (gate_q)
   );

   assign pf_gate = gate_q.pf;
   assign ls_gate = gate_q.ls;
   assign hs_gate = gate_q.hs;
   assign ht_gate = gate_q.ht;
   assign oc_flag = fault_q;

endmodule

// File: rtl/gim_checker.sv
module gim_checker #(
   parameter int unsigned ILK_MODE = 1,
   parameter int unsigned CLR_MODE = 1
) (
   input logic clk,
   input logic rst_n,
   input logic drv_en,
   input logic op_mode,
   input logic uv_clr,
   input logic pf_in,
   input logic ls_in,
   input logic hs_in,
   input logic ht_in,
   input logic oc_trip,
   input logic pf_gate,
   input logic ls_gate,
   input logic hs_gate,
   input logic ht_gate,
   input logic oc_flag
);

   logic clr_cond;
   assign clr_cond = (CLR_MODE == 1) ? (!ls_in && !hs_in && !oc_trip) : !oc_trip;

   assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |=> (!pf_gate && !ls_gate && !hs_gate && !ht_gate));

   assert_never_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ls_gate && hs_gate));

   assert_conflict_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ILK_MODE == 1 && ls_in && hs_in) |=> (!ls_gate && !hs_gate));

   assert_trip_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode && oc_trip && !uv_clr) |=> (oc_flag && !ls_gate && !hs_gate));

   assert_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_mode && !oc_flag) |=> !oc_flag);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_flag && !uv_clr && !clr_cond) |=> oc_flag);

   assert_uv_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uv_clr |=> !oc_flag);

   assert_aux_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |=> (pf_gate == $past(pf_in) && ht_gate == $past(ht_in)));

endmodule

bind gim_top gim_checker #(.ILK_MODE(ILK_MODE), .CLR_MODE(CLR_MODE)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .drv_en  (drv_en),
   .op_mode (op_mode),
   .uv_clr  (uv_clr),
   .pf_in   (pf_in),
   .ls_in   (ls_in),
   .hs_in   (hs_in),
   .ht_in   (ht_in),
   .oc_trip (oc_trip),
   .pf_gate (pf_gate),
   .ls_gate (ls_gate),
   .hs_gate (hs_gate),
   .ht_gate (ht_gate),
   .oc_flag (oc_flag)
);

// File: tb/gim_top_tb.sv
module gim_top_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic drv_en = 0, op_mode = 0, uv_clr = 0;
   logic pf_in = 0, ls_in = 0, hs_in = 0, ht_in = 0, oc_trip = 0;
   logic pf_gate, ls_gate, hs_gate, ht_gate, oc_flag;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic m_fault = 0;

   always #5 clk = ~clk;

   gim_top u_dut (
      .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .op_mode(op_mode), .uv_clr(uv_clr),
      .pf_in(pf_in), .ls_in(ls_in), .hs_in(hs_in), .ht_in(ht_in), .oc_trip(oc_trip),
      .pf_gate(pf_gate), .ls_gate(ls_gate), .hs_gate(hs_gate), .ht_gate(ht_gate),
      .oc_flag(oc_flag)
   );

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: outputs {pf,ls,hs,ht,flag} actual=%b expected=%b", req, act, exp);
      end
   endtask

   // v bits: 7 drv_en, 6 op_mode, 5 uv_clr, 4 pf, 3 ls, 2 hs, 1 ht, 0 trip
   task automatic apply(input logic [7:0] v, input string req);
      logic nf;
      logic [4:0] exp;
      {drv_en, op_mode, uv_clr, pf_in, ls_in, hs_in, ht_in, oc_trip} = v;
      if (v[5])              nf = 1'b0;
      else if (v[6] && v[0]) nf = 1'b1;
      else if (!v[3] && !v[2] && !v[0]) nf = 1'b0;
      else                   nf = m_fault;
      m_fault = nf;
      exp[4] = v[7] & v[4];
      exp[3] = v[7] & v[3] & ~v[2] & ~nf;
      exp[2] = v[7] & v[2] & ~v[3] & ~nf;
      exp[1] = v[7] & v[1];
      exp[0] = nf;
      @(posedge clk);
      @(negedge clk);
      chk(req, {pf_gate, ls_gate, hs_gate, ht_gate, oc_flag}, exp);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 in reset", {pf_gate, ls_gate, hs_gate, ht_gate, oc_flag}, 5'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {pf_gate, ls_gate, hs_gate, ht_gate, oc_flag}, 5'b0);

      // R2 disabled drivers
      apply(8'b0001_1110, "R2 disabled all inputs high");
      // R3 pass-through
      apply(8'b1001_0010, "R3 pf ht high");
      apply(8'b1000_1000, "R3 low side");
      apply(8'b1000_0100, "R3 high side");
      // R4 interlock and release
      apply(8'b1000_1100, "R4 conflict blanks");
      apply(8'b1000_1000, "R4 release");
      // R6 trip ignored outside operating mode
      apply(8'b1000_1001, "R6 unarmed trip");
      // R5 trip sets
      apply(8'b1101_1001, "R5 trip sets");
      // R7 hold while partial release
      apply(8'b1100_0100, "R7 hs still high");
      apply(8'b1000_0001, "R7 sense still high");
      apply(8'b1100_1000, "R7 ls still high");
      // R9 aux unaffected by fault
      apply(8'b1101_0110, "R9 aux during fault");
      // R7 full release
      apply(8'b1100_0000, "R7 release");
      // R10 no fault in operating mode
      apply(8'b1100_1000, "R10 flag low");
      // R8 uv clear beats trip
      apply(8'b1100_0001, "R5 set again");
      apply(8'b1110_1101, "R8 uv beats trip");

      // near-exhaustive scrambled sweep
      for (int pass = 0; pass < 4; pass++) begin
         for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + pass * 91) % 256);
            apply(v, "R3/R4/R5/R7/R8/R9 sweep");
         end
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule